// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

The block sits on a narrow command bus and turns a short serial burst of bytes into one register write. Each command is six bytes on six consecutive clock cycles. The first byte carries a strobe, and the strobe marks where the frame starts. The first two bytes form a 16-bit address, low byte first. The last four bytes form a 32-bit data word, least significant byte first. Everything runs in one clock domain with a synchronous, active-high reset.

The full address is compared against a base address, but only in the bit positions that a mask selects. Base and mask are parameters. When a command's address falls inside the window, the block presents three outputs for a downstream register bank: the free low address bits as a local register index, the assembled data word, and a write-enable that lasts one cycle. Commands outside the window pass without effect, so several such blocks can share one bus, each with its own window.

Top module: `cmdser_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the write-enable is 0 and the index and data outputs are 0. Reset also abandons any frame in progress.
- R2: A frame is six bytes on consecutive cycles, and the strobe comes with the first byte only. The address low byte comes first, then the address high byte, then data bytes 0 to 3.
- R3: Data byte 0 lands in bits 7:0 of the data output, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24.
- R4: A frame is accepted only if ((address XOR BASE) AND MASK) equals 0. The defaults are BASE = 0x0330 and MASK = 0x07F8.
- R5: For an accepted frame, the index output equals address bits 2:0.
- R6: The write-enable is high for exactly one cycle: the cycle right after the one in which the sixth byte is on the bus. It is low during the frame.
- R7: The index and data outputs change only together with a write-enable. A rejected frame leaves them unchanged.
- R8: A strobe inside a frame, including on the sixth byte position, drops the partial frame. That byte then becomes byte 0 of a new frame.
- R9: Bytes without a strobe while no frame is open are ignored and cause no write-enable.
- R10: If reset arrives during a frame, that frame gives no write-enable, even when its remaining bytes are still sent afterwards.
- R11: Frames sent back to back with no idle cycle between them are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte_i | input | 8 | Serial command byte |
| cmd_strb_i | input | 1 | Marks the first byte of a frame |
| wr_en_o | output | 1 | One-cycle write-enable for an accepted frame |
| wr_idx_o | output | LOCAL_W (3) | Local register index |
| wr_data_o | output | 32 | Assembled data word |

## Verification
Two situations are hard to reach from the ports. The first is a frame that has to be thrown away after it has already gathered most of its bytes, with the new strobe landing exactly on the last byte position. The bench reaches this by cutting a frame short after three bytes and after five bytes and starting the next frame immediately, with no idle cycle. Its data then has to win completely over the partial frame. The second is a reset that lands mid-frame while the remaining bytes keep arriving. Both the write-enable and the cleared outputs are watched for several cycles after that reset.

// File: rtl/cmdser_pkg.sv
`timescale 1ns/1ps
package cmdser_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 2;
    localparam int DATA_BYTES  = 4;
    localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES;
    localparam int ADDR_W      = BYTE_W * ADDR_BYTES;
    localparam int DATA_W      = BYTE_W * DATA_BYTES;
    localparam int POS_W       = $clog2(FRAME_BYTES);
    localparam int LAST_POS    = FRAME_BYTES - 1;

    typedef logic [BYTE_W-1:0] cmd_byte_t;
    typedef logic [ADDR_W-1:0] cmd_addr_t;
    typedef logic [DATA_W-1:0] cmd_data_t;
    typedef logic [POS_W-1:0]  pos_t;

    // position of the byte currently on the bus inside a frame
    typedef struct packed {
        logic valid;
        pos_t pos;
    } byte_slot_t;

    // assembled frame; the address occupies the low bits, as on the wire
    typedef struct packed {
        cmd_data_t data;
        cmd_addr_t addr;
    } cmd_frame_t;

    function automatic logic addr_selects(cmd_addr_t a, cmd_addr_t base, cmd_addr_t mask);
        return ((a ^ base) & mask) == '0;
    endfunction

    function automatic pos_t pos_of(int unsigned n);
        return pos_t'(n);
    endfunction

endpackage

// File: rtl/cmdser_framer.sv
`timescale 1ns/1ps
module cmdser_framer
    import cmdser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strb_i,
    output byte_slot_t slot_o,
    output logic       last_o
);

    logic open_q;
    pos_t next_q;

    // a strobe always wins: it restarts the frame at byte 0
    always_comb begin
        slot_o.valid = strb_i | open_q;
        slot_o.pos   = strb_i ? '0 : next_q;
    end

    assign last_o = slot_o.valid && (slot_o.pos == pos_of(LAST_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            next_q <= '0;
        end else if (slot_o.valid) begin
            if (last_o) begin
                open_q <= 1'b0;
                next_q <= '0;
            end else begin
                open_q <= 1'b1;
                next_q <= slot_o.pos + pos_of(1);
            end
        end
    end

endmodule

// File: rtl/cmdser_collect.sv
`timescale 1ns/1ps
module cmdser_collect
    import cmdser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_byte_t  byte_i,
    input  byte_slot_t slot_i,
    output cmd_frame_t frame_o
);

    logic [FRAME_BYTES*BYTE_W-1:0] flat;

    // one holding lane per byte except the last, which is taken live
    for (genvar g = 0; g < LAST_POS; g++) begin : g_lane
        cmd_byte_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (slot_i.valid && slot_i.pos == pos_of(g))
                q <= byte_i;
        end
        assign flat[g*BYTE_W +: BYTE_W] = q;
    end

    assign flat[LAST_POS*BYTE_W +: BYTE_W] = byte_i;
    assign frame_o = cmd_frame_t'(flat);

endmodule

// File: rtl/cmdser_decode.sv
`timescale 1ns/1ps
module cmdser_decode
    import cmdser_pkg::*;
#(
    parameter cmd_addr_t BASE    = 16'h0330,
    parameter cmd_addr_t MASK    = 16'h07F8,
    parameter int        LOCAL_W = 3
) (
    input  cmd_addr_t          addr_i,
    output logic               hit_o,
    output logic [LOCAL_W-1:0] idx_o
);

    assign hit_o = addr_selects(addr_i, BASE, MASK);
    assign idx_o = addr_i[LOCAL_W-1:0];

endmodule

// File: rtl/cmdser_top.sv
`timescale 1ns/1ps
module cmdser_top
    import cmdser_pkg::*;
#(
    parameter cmd_addr_t BASE    = 16'h0330,
    parameter cmd_addr_t MASK    = 16'h07F8,
    parameter int        LOCAL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cmd_byte_i,
    input  logic               cmd_strb_i,
    output logic               wr_en_o,
    output logic [LOCAL_W-1:0] wr_idx_o,
    output logic [31:0]        wr_data_o
);

    byte_slot_t         slot;
    logic               last;
    cmd_frame_t         frame;
    logic               hit;
    logic [LOCAL_W-1:0] idx;

    cmdser_framer u_framer (
        .clk    (clk),
        .rst    (rst),
        .strb_i (cmd_strb_i),
        .slot_o (slot),
        .last_o (last)
    );

    cmdser_collect u_collect (
        .clk     (clk),
        .rst     (rst),
        .byte_i  (cmd_byte_i),
        .slot_i  (slot),
        .frame_o (frame)
    );

    cmdser_decode #(
        .BASE    (BASE),
        .MASK    (MASK),
        .LOCAL_W (LOCAL_W)
    ) u_decode (
        .addr_i (frame.addr),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= last && hit;
            if (last && hit) begin
                wr_idx_o  <= idx;
                wr_data_o <= frame.data;
            end
        end
    end

endmodule

// File: rtl/cmdser_checker.sv
`timescale 1ns/1ps
module cmdser_checker
    import cmdser_pkg::*;
#(
    parameter cmd_addr_t BASE    = 16'h0330,
    parameter cmd_addr_t MASK    = 16'h07F8,
    parameter int        LOCAL_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         cmd_byte_i,
    input logic               cmd_strb_i,
    input logic               wr_en_o,
    input logic [LOCAL_W-1:0] wr_idx_o,
    input logic [31:0]        wr_data_o
);

    localparam int AGE_W = $clog2(FRAME_BYTES + 2);

    logic [AGE_W-1:0] age_q;
    logic [7:0]       cap_lo_q, cap_hi_q;

    // cycles since the latest strobe, saturating; cleared by reset
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (cmd_strb_i)
            age_q <= AGE_W'(1);
        else if (age_q != '0 && age_q <= AGE_W'(FRAME_BYTES))
            age_q <= age_q + AGE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (cmd_strb_i)
            cap_lo_q <= cmd_byte_i;
        if (!cmd_strb_i && age_q == AGE_W'(1))
            cap_hi_q <= cmd_byte_i;
    end

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_en_o && wr_idx_o == '0 && wr_data_o == '0));

    // R2, R8, R10: a write needs an unbroken frame since the last strobe
    assert_frame_age_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (age_q == AGE_W'(FRAME_BYTES)));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (((({cap_hi_q, cap_lo_q}) ^ BASE) & MASK) == '0));

    assert_index_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o == cap_lo_q[LOCAL_W-1:0]));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_o && !$past(rst)) |-> ($stable(wr_idx_o) && $stable(wr_data_o)));

endmodule

bind cmdser_top cmdser_checker #(
    .BASE    (BASE),
    .MASK    (MASK),
    .LOCAL_W (LOCAL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_byte_i (cmd_byte_i),
    .cmd_strb_i (cmd_strb_i),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
);

// File: tb/tb_cmdser_top.sv
`timescale 1ns/1ps
module tb_cmdser_top;

    localparam logic [15:0] BASE = 16'h0330;
    localparam logic [15:0] MASK = 16'h07F8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ad  = 8'h00;
    logic       strb = 1'b0;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [31:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2:0]  exp_idx  = '0;
    logic [31:0] exp_data = '0;

    // values sampled at the negedge where the most recent byte was driven
    logic        s_we;
    logic [2:0]  s_idx;
    logic [31:0] s_data;
    logic        f0_we;
    logic [2:0]  f0_idx;
    logic [31:0] f0_data;

    always #2 clk = ~clk;

    cmdser_top dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_byte_i (ad),
        .cmd_strb_i (strb),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // sample outputs at the negedge, then drive the next byte
    task automatic drive(input logic s, input logic [7:0] b);
        @(negedge clk);
        s_we   = wr_en;
        s_idx  = wr_idx;
        s_data = wr_data;
        strb   = s;
        ad     = b;
    endtask

    function automatic logic [7:0] frame_byte(input logic [15:0] a, input logic [31:0] d, input int k);
        return (k < 2) ? a[8*k +: 8] : d[8*(k-2) +: 8];
    endfunction

    function automatic bit in_window(input logic [15:0] a);
        return ((a ^ BASE) & MASK) == 16'h0;
    endfunction

    task automatic send(input logic [15:0] a, input logic [31:0] d, input int n);
        for (int k = 0; k < n; k++) begin
            drive(k == 0, frame_byte(a, d, k));
            if (k == 0) begin
                f0_we = s_we; f0_idx = s_idx; f0_data = s_data;
            end else begin
                check("R6 no write-enable inside frame", 32'(s_we), 32'd0);
            end
        end
    endtask

    // one idle cycle, then verify the write result of the frame just sent
    task automatic finish_frame(input logic [15:0] a, input logic [31:0] d, input string req);
        bit h;
        h = in_window(a);
        drive(1'b0, 8'h00);
        check({req, " write-enable after sixth byte (R6)"}, 32'(s_we), 32'(h));
        if (h) begin
            exp_idx  = a[2:0];
            exp_data = d;
        end
        check({req, " index (R5/R7)"}, 32'(s_idx), 32'(exp_idx));
        check({req, " data (R3/R7)"}, s_data, exp_data);
        drive(1'b0, 8'h00);
        check("R6 write-enable lasts one cycle", 32'(s_we), 32'd0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [31:0] d;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 write-enable in reset", 32'(wr_en), 32'd0);
        check("R1 index in reset", 32'(wr_idx), 32'd0);
        check("R1 data in reset", wr_data, 32'd0);
        rst = 1'b0;
        drive(1'b0, 8'h00);
        check("R1 write-enable after reset", 32'(s_we), 32'd0);

        // R3: explicit byte placement
        send(16'h0334, 32'h44332211, 6);
        finish_frame(16'h0334, 32'h44332211, "R3 byte order");

        // R5: every local index inside the window
        for (int i = 0; i < 8; i++) begin
            a = BASE | 16'(i);
            d = 32'hA1B2C3D4 ^ (32'(i) * 32'h01010101);
            send(a, d, 6);
            finish_frame(a, d, "R5 index sweep");
        end

        // R4: every single-bit address flip; masked-off bits still match
        for (int b = 0; b < 16; b++) begin
            a = 16'h0335 ^ (16'h1 << b);
            d = 32'h10000000 + 32'(b) * 32'h00130507;
            send(a, d, 6);
            finish_frame(a, d, "R4 window sweep");
        end

        // R7: a rejected frame leaves outputs unchanged
        send(16'h1234, 32'hDEADBEEF, 6);
        finish_frame(16'h1234, 32'hDEADBEEF, "R7 reject");

        // R9: unstrobed bytes while idle are ignored
        for (int k = 0; k < 12; k++) begin
            drive(1'b0, 8'h30 + 8'(k));
            check("R9 idle bytes give no write-enable", 32'(s_we), 32'd0);
            check("R9 idle bytes leave data", s_data, exp_data);
        end

        // R8: strobe after three bytes restarts the frame
        send(16'h0331, 32'h0BADF00D, 3);
        send(16'h0336, 32'h5A5A1234, 6);
        finish_frame(16'h0336, 32'h5A5A1234, "R8 restart after three");

        // R8: strobe on the sixth byte position restarts too
        send(16'h0332, 32'hCAFE0001, 5);
        check("R8 no write-enable before restart", 32'(s_we), 32'd0);
        send(16'h0337, 32'h76543210, 6);
        check("R8 partial frame not written", 32'(f0_we), 32'd0);
        finish_frame(16'h0337, 32'h76543210, "R8 restart on last position");

        // R11: back-to-back frames
        send(16'h0333, 32'h11112222, 6);
        send(16'h0335, 32'h33334444, 6);
        check("R11 first frame write-enable", 32'(f0_we), 32'd1);
        check("R11 first frame index", 32'(f0_idx), 32'd3);
        check("R11 first frame data", f0_data, 32'h11112222);
        finish_frame(16'h0335, 32'h33334444, "R11 second frame");

        // R10: reset mid-frame, remaining bytes still arrive
        send(16'h0332, 32'h99887766, 4);
        @(negedge clk);
        rst = 1'b1;
        ad  = frame_byte(16'h0332, 32'h99887766, 4);
        strb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ad  = frame_byte(16'h0332, 32'h99887766, 5);
        exp_idx  = '0;
        exp_data = '0;
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 8'h00);
            check("R10 no write-enable after mid-frame reset", 32'(s_we), 32'd0);
            check("R10 data cleared by reset", s_data, 32'd0);
            check("R10 index cleared by reset", 32'(s_idx), 32'd0);
        end

        // after recovery a normal frame works
        send(16'h0331, 32'h0F0E0D0C, 6);
        finish_frame(16'h0331, 32'h0F0E0D0C, "R2 frame after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule